// File: doc/BRIEF.md
# Serial Receive Byte Queue with Fill-Level Interrupt

This block sits behind a serial receiver's shift logic and in front of a host read port. Each completed frame arrives as a one-cycle valid pulse. The pulse carries a data byte, a ninth bit and a parity-error flag. The block keeps these frames in a chain of up to three storage stages:

- a capture stage, standing for the shift register;
- a holding register;
- a small queue.

The host reads frames oldest first. The parity flag and the ninth bit travel with every byte.

The host programs a fill level. The queue never holds more entries than that level, and an interrupt is held high while the queue is at the level. Optionally the block stops reception by dropping its receive enable once every active stage is full. With a level of four, exactly six frames are kept: four in the queue, one in the holding register and one in the capture stage.

When the holding register is disabled, only the capture stage is used. When the holding register is enabled but the queue is not, the capture stage feeds the holding register. The queue is used only when both are enabled.

Top module: `rxq_top`

## Requirements
- R1: After reset the receive enable is 0, the fill count is 0, the empty flag is 1, and the overrun flag and the interrupt are 0. Frames that arrive while the receive enable is 0 are not stored. A one-cycle start pulse sets the receive enable.
- R2: Frames move from the capture stage to the holding register and then into the queue. Reads return frames in arrival order.
- R3: The 2-bit level code maps 00 to a level of 4 and 01, 10, 11 to levels 1, 2, 3. The queue never holds more entries than the active level.
- R4: In queue mode the interrupt is 1 while the fill count is at least the active level and 0 once the count falls below it.
- R5: When auto-inhibit is set and every active stage is full, the receive enable drops to 0 and later frames are ignored without raising overrun. With level 4 exactly six frames are kept.
- R6: A level code change takes effect only on a clear pulse. The clear pulse also empties the queue.
- R7: While wake mode is on, a frame whose ninth bit is 0 is discarded and raises no interrupt. A frame whose ninth bit is 1 is stored.
- R8: Each stored frame keeps its own parity-error flag and ninth bit, and these are returned with its byte on the read port.
- R9: A frame that arrives while the capture stage is full and cannot advance is dropped and sets a sticky overrun flag. A status-read pulse clears the flag.
- R10: The queue is used only when both the holding enable and the queue enable are 1.
  - With the holding register only, reads come from the holding register and the interrupt follows its occupancy.
  - With neither, reads come from the capture stage.
  - In both cases the fill count stays 0.
- R11: The fill count gives the number of queue entries (0 to 4). The empty flag is 1 exactly when that count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a frame is complete |
| rx_data | input | DATA_W (8) | Received byte |
| rx_bit9 | input | 1 | Received ninth bit |
| rx_perr | input | 1 | Parity error for this frame |
| cfg_hold_en | input | 1 | Enable the holding register |
| cfg_queue_en | input | 1 | Enable the queue (needs cfg_hold_en) |
| cfg_auto_inh | input | 1 | Drop receive enable when all stages are full |
| cfg_wake | input | 1 | Store only frames with ninth bit 1 |
| cfg_level | input | LVL_W (2) | Fill level code, loaded on clr_queue |
| clr_queue | input | 1 | Empty the queue and load the level code |
| rx_start | input | 1 | Set the receive enable |
| rd_pop | input | 1 | Consume the frame on the read port |
| stat_rd | input | 1 | Status read; clears overrun |
| rd_data | output | DATA_W (8) | Oldest readable byte |
| rd_bit9 | output | 1 | Ninth bit of that frame |
| rd_perr | output | 1 | Parity flag of that frame |
| fill_cnt | output | CNT_W (3) | Queue entries in use |
| q_empty | output | 1 | Queue empty |
| ovr_flag | output | 1 | Sticky overrun |
| rx_irq | output | 1 | Receive interrupt |
| rx_enable | output | 1 | Receive enable |

## Verification
The assertions check on every cycle that:
- the queue never holds more entries than the active level;
- the capture stage stays empty while reception is disabled or a wake-mode frame is filtered;
- overrun holds until a status read;
- the receive enable falls on the cycle after the stages fill under auto-inhibit.

Only the bench scenarios can show the following:
- arrival order through all three stages, and that flags stay with their bytes;
- the six-frame count at level 4;
- that a level change waits for a clear;
- how reads are routed in the two reduced modes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      RXM_SINGLE = 2'd0,
      RXM_DOUBLE = 2'd1,
      RXM_QUEUE  = 2'd2
   } rxq_mode_e;

   // level code zero selects the full depth, other codes are the level itself
   function automatic int unsigned rxq_level(input int unsigned code, input int unsigned depth);
      return (code == 0) ? depth : code;
   endfunction

   function automatic rxq_mode_e rxq_mode(input logic hold_en, input logic queue_en);
      if (!hold_en)
         return RXM_SINGLE;
      else if (queue_en)
         return RXM_QUEUE;
      else
         return RXM_DOUBLE;
   endfunction

endpackage

// File: rtl/rxq_stage.sv
module rxq_stage #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         unload,
   input  logic [W-1:0] din,
   output logic         valid,
   output logic [W-1:0] dout
);

   generate
      if (W < 1) begin : g_bad_w
         $error("rxq_stage: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         if (load) begin
            valid <= 1'b1;
            dout  <= din;
         end else if (unload) begin
            valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push && !flush) begin
         mem[wptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rptr];

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (count < CNT_W'(DEPTH)));

   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int LVL_W = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rxq_mode_e        mode,
   input  logic             rx_start,
   input  logic             auto_inh,
   input  logic             full_all,
   input  logic             lost,
   input  logic             stat_rd,
   input  logic             clr_queue,
   input  logic [LVL_W-1:0] lvl_code,
   input  logic [CNT_W-1:0] count,
   input  logic             hold_v,
   input  logic             cap_v,
   output logic             rx_enable,
   output logic             ovr_flag,
   output logic [CNT_W-1:0] level_q,
   output logic             irq
);

   generate
      if ((1 << LVL_W) != DEPTH) begin : g_bad_lvl
         $error("rxq_ctrl: level code must span the queue depth");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_enable <= 1'b0;
         ovr_flag  <= 1'b0;
         level_q   <= CNT_W'(DEPTH);
      end else begin
         if (rx_start)
            rx_enable <= 1'b1;
         else if (auto_inh && full_all)
            rx_enable <= 1'b0;

         if (lost)
            ovr_flag <= 1'b1;
         else if (stat_rd)
            ovr_flag <= 1'b0;

         if (clr_queue)
            level_q <= CNT_W'(rxq_level(32'(lvl_code), DEPTH));
      end
   end

   always_comb begin
      case (mode)
         RXM_QUEUE:  irq = (count >= level_q);
         RXM_DOUBLE: irq = hold_v;
         default:    irq = cap_v;
      endcase
   end

   // R5
   auto_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_inh && full_all && !rx_start) |=> !rx_enable);

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !stat_rd) |=> ovr_flag);

   // R9
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !lost) |=> !ovr_flag);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int LVL_W  = 2,
   localparam int WORD_W = DATA_W + 2,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_bit9,
   input  logic              rx_perr,
   input  logic              cfg_hold_en,
   input  logic              cfg_queue_en,
   input  logic              cfg_auto_inh,
   input  logic              cfg_wake,
   input  logic [LVL_W-1:0]  cfg_level,
   input  logic              clr_queue,
   input  logic              rx_start,
   input  logic              rd_pop,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rd_perr,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              q_empty,
   output logic              ovr_flag,
   output logic              rx_irq,
   output logic              rx_enable
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("rxq_top: DATA_W must be positive");
      end
   endgenerate

   rxq_mode_e          mode;
   logic               in_q;
   logic               cap_v, hold_v;
   logic [WORD_W-1:0]  cap_w, hold_w, q_w, in_w, out_w;
   logic               at_level, hold_adv, cap_adv, rd_hit;
   logic               cap_unload, hold_unload, q_pop;
   logic               frame_ok, cap_load, lost, full_all;
   logic [CNT_W-1:0]   level_q;

   assign mode = rxq_mode(cfg_hold_en, cfg_queue_en);
   assign in_q = (mode == RXM_QUEUE);
   assign in_w = {rx_perr, rx_bit9, rx_data};

   // movement along the chain, based on the registered state of each stage
   assign at_level = (fill_cnt >= level_q);
   assign hold_adv = in_q && hold_v && !at_level && !clr_queue;
   assign cap_adv  = (mode != RXM_SINGLE) && cap_v && (!hold_v || hold_adv);

   always_comb begin
      case (mode)
         RXM_SINGLE: begin rd_hit = rd_pop && cap_v;    out_w = cap_w;  end
         RXM_DOUBLE: begin rd_hit = rd_pop && hold_v;   out_w = hold_w; end
         default:    begin rd_hit = rd_pop && !q_empty; out_w = q_w;    end
      endcase
   end

   assign cap_unload  = cap_adv || ((mode == RXM_SINGLE) && rd_hit);
   assign hold_unload = hold_adv || ((mode == RXM_DOUBLE) && rd_hit);
   assign q_pop       = in_q && rd_hit && !clr_queue;

   assign frame_ok = rx_valid && rx_enable && !(cfg_wake && !rx_bit9);
   assign cap_load = frame_ok && (!cap_v || cap_unload);
   assign lost     = frame_ok && cap_v && !cap_unload;
   assign full_all = cap_v && ((mode == RXM_SINGLE) || hold_v) && (!in_q || at_level);

   rxq_stage #(.W(WORD_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cap_load),
      .unload (cap_unload),
      .din    (in_w),
      .valid  (cap_v),
      .dout   (cap_w)
   );

   rxq_stage #(.W(WORD_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cap_adv),
      .unload (hold_unload),
      .din    (cap_w),
      .valid  (hold_v),
      .dout   (hold_w)
   );

   rxq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (clr_queue),
      .push  (hold_adv),
      .pop   (q_pop),
      .din   (hold_w),
      .dout  (q_w),
      .count (fill_cnt)
   );

   rxq_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .rx_start  (rx_start),
      .auto_inh  (cfg_auto_inh),
      .full_all  (full_all),
      .lost      (lost),
      .stat_rd   (stat_rd),
      .clr_queue (clr_queue),
      .lvl_code  (cfg_level),
      .count     (fill_cnt),
      .hold_v    (hold_v),
      .cap_v     (cap_v),
      .rx_enable (rx_enable),
      .ovr_flag  (ovr_flag),
      .level_q   (level_q),
      .irq       (rx_irq)
   );

   assign q_empty = (fill_cnt == '0);
   assign {rd_perr, rd_bit9, rd_data} = out_w;

   // R3
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= level_q);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && !cap_v) |=> !cap_v);

   // R7
   wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && cfg_wake && rx_valid && !rx_bit9 && !cap_v) |=> !cap_v);

   // R10
   no_queue_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_q && q_empty && !clr_queue) |=> q_empty);

endmodule

// File: tb/rxq_top_tb.sv
module rxq_top_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_bit9 = 1'b0;
   logic       rx_perr = 1'b0;
   logic       cfg_hold_en = 1'b1;
   logic       cfg_queue_en = 1'b1;
   logic       cfg_auto_inh = 1'b0;
   logic       cfg_wake = 1'b0;
   logic [1:0] cfg_level = 2'b00;
   logic       clr_queue = 1'b0;
   logic       rx_start = 1'b0;
   logic       rd_pop = 1'b0;
   logic       stat_rd = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, rd_perr;
   logic [2:0] fill_cnt;
   logic       q_empty, ovr_flag, rx_irq, rx_enable;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;
   logic [9:0] sb_q [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rxq_top u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_perr(rx_perr), .cfg_hold_en(cfg_hold_en),
      .cfg_queue_en(cfg_queue_en), .cfg_auto_inh(cfg_auto_inh), .cfg_wake(cfg_wake),
      .cfg_level(cfg_level), .clr_queue(clr_queue), .rx_start(rx_start),
      .rd_pop(rd_pop), .stat_rd(stat_rd), .rd_data(rd_data), .rd_bit9(rd_bit9),
      .rd_perr(rd_perr), .fill_cnt(fill_cnt), .q_empty(q_empty), .ovr_flag(ovr_flag),
      .rx_irq(rx_irq), .rx_enable(rx_enable)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // driver: sends one frame and records it when the requirements say it is kept
   task automatic send(input logic [7:0] d, input logic b9, input logic pe, input bit keep);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_bit9 = b9; rx_perr = pe;
      @(negedge clk);
      rx_valid = 1'b0;
      if (keep) sb_q.push_back({pe, b9, d});
      settle();
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_pop = 1'b1;
      @(negedge clk); rd_pop = 1'b0;
      settle();
   endtask

   task automatic pulse_start();
      @(negedge clk); rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_queue = 1'b1;
      @(negedge clk); clr_queue = 1'b0;
      settle();
   endtask

   task automatic pulse_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
      settle();
   endtask

   // monitor: compares the read port against the scoreboard whenever a read is issued (R2, R8)
   always @(negedge clk) begin
      #1;
      if (rd_pop) begin
         n_tests++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2: read with no frame expected, actual %0h expected none",
                     {rd_perr, rd_bit9, rd_data});
         end else begin
            logic [9:0] e;
            e = sb_q.pop_front();
            if ({rd_perr, rd_bit9, rd_data} !== e) begin
               n_fail++;
               $display("FAIL R2/R8: read word actual %0h expected %0h",
                        {rd_perr, rd_bit9, rd_data}, e);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx_enable", rx_enable, 0);
      chk("R1 fill", fill_cnt, 0);
      chk("R1 empty", q_empty, 1);
      chk("R1 irq", rx_irq, 0);
      chk("R1 ovr", ovr_flag, 0);
      send(8'h99, 0, 0, 0);
      chk("R1 ignored while disabled", fill_cnt, 0);
      pulse_start();
      chk("R1 start sets enable", rx_enable, 1);

      // queue mode, level 4 after reset
      send(8'h11, 0, 0, 1);
      send(8'h22, 0, 1, 1);
      send(8'h33, 1, 0, 1);
      chk("R11 fill three", fill_cnt, 3);
      chk("R11 not empty", q_empty, 0);
      chk("R4 below level", rx_irq, 0);
      send(8'h44, 0, 0, 1);
      chk("R3 level4 fill", fill_cnt, 4);
      chk("R4 at level", rx_irq, 1);
      pulse_rd();
      chk("R4 drops below", rx_irq, 0);
      chk("R11 fill after read", fill_cnt, 3);
      repeat (3) pulse_rd();
      chk("R11 empty after reads", q_empty, 1);

      // auto-inhibit with level 4: six frames kept
      cfg_auto_inh = 1'b1;
      for (int i = 1; i <= 6; i++) send(8'hA0 + 8'(i), 0, 0, 1);
      chk("R5 enable dropped", rx_enable, 0);
      chk("R5 fill four", fill_cnt, 4);
      chk("R5 irq", rx_irq, 1);
      send(8'hA7, 0, 0, 0);
      chk("R5 no overrun", ovr_flag, 0);
      repeat (6) pulse_rd();
      chk("R5 six frames drained", q_empty, 1);
      chk("R5 scoreboard drained", sb_q.size(), 0);
      cfg_auto_inh = 1'b0;

      // level change waits for clear
      pulse_start();
      cfg_level = 2'b01;
      send(8'hB1, 0, 0, 1);
      send(8'hB2, 0, 0, 1);
      chk("R6 old level still active fill", fill_cnt, 2);
      chk("R6 old level still active irq", rx_irq, 0);
      pulse_clr();
      sb_q.delete();
      chk("R6 clear empties", fill_cnt, 0);
      chk("R6 clear empty flag", q_empty, 1);
      send(8'hC1, 0, 0, 1);
      chk("R4 level1 irq", rx_irq, 1);
      send(8'hC2, 0, 1, 1);
      send(8'hC3, 1, 0, 1);
      chk("R3 level1 cap", fill_cnt, 1);
      chk("R9 no overrun yet", ovr_flag, 0);
      send(8'hC4, 0, 0, 0);
      chk("R9 overrun set", ovr_flag, 1);
      settle();
      chk("R9 overrun sticky", ovr_flag, 1);
      pulse_stat();
      chk("R9 status clears", ovr_flag, 0);
      pulse_rd();
      chk("R4 refilled irq", rx_irq, 1);
      pulse_rd();
      pulse_rd();
      chk("R2 drained", q_empty, 1);
      chk("R4 empty irq", rx_irq, 0);

      // wake mode, level 2
      cfg_level = 2'b10;
      pulse_clr();
      cfg_wake = 1'b1;
      send(8'hD0, 0, 0, 0);
      chk("R7 filtered fill", fill_cnt, 0);
      chk("R7 filtered irq", rx_irq, 0);
      send(8'hD1, 1, 0, 1);
      chk("R7 kept fill", fill_cnt, 1);
      chk("R3 level2 irq low", rx_irq, 0);
      send(8'hD2, 1, 1, 1);
      chk("R3 level2 irq high", rx_irq, 1);
      repeat (2) pulse_rd();
      cfg_wake = 1'b0;

      // reduced modes
      cfg_queue_en = 1'b0;
      send(8'hE1, 0, 1, 1);
      chk("R10 hold fill zero", fill_cnt, 0);
      chk("R10 hold irq", rx_irq, 1);
      pulse_rd();
      chk("R10 hold irq after read", rx_irq, 0);
      cfg_hold_en = 1'b0;
      cfg_queue_en = 1'b1;
      send(8'hE2, 1, 0, 1);
      chk("R10 single fill zero", fill_cnt, 0);
      chk("R10 single irq", rx_irq, 1);
      pulse_rd();
      chk("R10 single irq after read", rx_irq, 0);
      chk("R2 scoreboard empty", sb_q.size(), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule